// File: doc/BRIEF.md
# Platform Reset Pulse Generator

This block turns a one-cycle reset request from a system controller into a timed reset pulse toward a platform hub. The request carries a select bit. A cold request pulls the hub's power-good line low for a fixed interval and then lets it return. A warm request drives an active-low init line low for a shorter interval and leaves power-good alone. Outside a cold dropout, the power-good output simply mirrors an external enable input. The enable input belongs to the rail sequencer, which is a separate block. Deciding when a reset is needed is also done elsewhere.

Pulse widths are given in nanoseconds and converted to clock cycles from a clock-frequency parameter in MHz, rounding up. The cold width is never allowed below a 91 µs floor. The warm width is never allowed below a 500 ns floor. The defaults are 100 µs for cold and 10 µs for warm. A busy flag covers the whole pulse. A request that arrives while a pulse runs is dropped. A cold request is also dropped when power-good is already low, because there is nothing to drop.

The control is a three-state machine:
- ST_IDLE, where no pulse runs.
- ST_COLD_DROP, where power-good is forced low.
- ST_WARM_PULSE, where the init line is low.

The transitions are:
- ST_IDLE to ST_COLD_DROP on an accepted cold request.
- ST_IDLE to ST_WARM_PULSE on an accepted warm request.
- Either pulse state back to ST_IDLE when the interval counter reaches zero.

Top module: `plat_rst_pulser`

## Requirements
- R1: While reset is applied the block is idle: `busy` is 0, `init_n` is 1, and `pgood` equals `pwr_en`.
- R2: Whenever no cold dropout is in progress, `pgood` follows `pwr_en` in the same cycle.
- R3: A cold request (`req_valid`=1, `req_cold`=1) accepted while idle with `pgood` high drives `pgood` low starting the cycle after the request. It stays low for exactly COLD_CYC cycles, where COLD_CYC = ceil(CLK_MHZ × max(COLD_NS, 91000) / 1000), which is 12500 at the defaults. After that, `pgood` follows `pwr_en` again.
- R4: A cold request that arrives while `pgood` is low is ignored: `busy` stays 0, `init_n` stays 1, and no dropout occurs.
- R5: A warm request (`req_valid`=1, `req_cold`=0) accepted while idle drives `init_n` low starting the next cycle. It stays low for exactly WARM_CYC cycles, where WARM_CYC = ceil(CLK_MHZ × max(WARM_NS, 500) / 1000), which is 1250 at the defaults. `pgood` keeps following `pwr_en` throughout.
- R6: `busy` is 1 in exactly the cycles in which a pulse is driven, and 0 otherwise.
- R7: A request of either kind that arrives while `busy` is 1 is dropped. It neither lengthens the running pulse nor starts a second one.
- R8: A request presented in the first idle cycle after a pulse ends is accepted.
- R9: A warm request is accepted regardless of the state of `pwr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_en | input | 1 | Power-good level from the rail sequencer |
| req_valid | input | 1 | One-cycle reset request strobe |
| req_cold | input | 1 | Request kind: 1 = cold, 0 = warm |
| pgood | output | 1 | Power-good toward the hub |
| init_n | output | 1 | Active-low reset-init toward the hub |
| busy | output | 1 | High while a pulse is in progress |

## Verification
The bench tries four request patterns:
- Cold with power-good high. This separates a real dropout, of exact length, from no pulse at all.
- Cold with power-good low. This shows that the skip path leaves every output untouched.
- Warm with power-good high.
- Warm with power-good low. Together with the previous case, this shows that the warm pulse ignores the enable level.

Requests injected in the middle of a running pulse separate a correct drop from one that reloads the counter or switches the pulse kind. A request issued in the first idle cycle after a pulse shows that no dead cycle follows the end of a pulse.

// File: rtl/plat_rst_pkg.sv
package plat_rst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_COLD_DROP  = 2'd1,
        ST_WARM_PULSE = 2'd2
    } pulse_state_e;

    // Convert a width in ns to clock cycles, rounding up, never below floor_ns.
    function automatic int ns_to_cycles(input int clk_mhz, input int ns, input int floor_ns);
        int eff;
        eff = (ns < floor_ns) ? floor_ns : ns;
        return (clk_mhz * eff + 999) / 1000;
    endfunction

endpackage

// File: rtl/plat_rst_arbiter.sv
module plat_rst_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_cold,
    input  logic idle,
    input  logic pgood_now,
    output logic take_cold,
    output logic take_warm
);

    always_comb begin
        take_cold = req_valid &&  req_cold && idle && pgood_now;
        take_warm = req_valid && !req_cold && idle;
    end

    // R7
    drop_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> !(take_cold || take_warm));

endmodule

// File: rtl/plat_rst_timer.sv
module plat_rst_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));

    // R7
    steady_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

endmodule

// File: rtl/plat_rst_pulser.sv
module plat_rst_pulser
    import plat_rst_pkg::*;
#(
    parameter int CLK_MHZ = 125,
    parameter int COLD_NS = 100000,
    parameter int WARM_NS = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    input  logic req_valid,
    input  logic req_cold,
    output logic pgood,
    output logic init_n,
    output logic busy
);

    localparam int COLD_FLOOR_NS = 91000;
    localparam int WARM_FLOOR_NS = 500;
    localparam int COLD_CYC  = ns_to_cycles(CLK_MHZ, COLD_NS, COLD_FLOOR_NS);
    localparam int WARM_CYC  = ns_to_cycles(CLK_MHZ, WARM_NS, WARM_FLOOR_NS);
    localparam int MAX_CYC   = (COLD_CYC > WARM_CYC) ? COLD_CYC : WARM_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] COLD_LOAD = CNT_W'(COLD_CYC - 1);
    localparam logic [CNT_W-1:0] WARM_LOAD = CNT_W'(WARM_CYC - 1);

    pulse_state_e     state_q, state_d;
    logic             take_cold, take_warm;
    logic             idle;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_cnt;
    logic [CNT_W-1:0] tmr_load_val;

    assign idle         = (state_q == ST_IDLE);
    assign tmr_load_val = take_cold ? COLD_LOAD : WARM_LOAD;

    plat_rst_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_cold  (req_cold),
        .idle      (idle),
        .pgood_now (pgood),
        .take_cold (take_cold),
        .take_warm (take_warm)
    );

    plat_rst_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_cold || take_warm),
        .load_val (tmr_load_val),
        .cnt      (tmr_cnt),
        .done     (tmr_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_cold)      state_d = ST_COLD_DROP;
                else if (take_warm) state_d = ST_WARM_PULSE;
            end
            ST_COLD_DROP:  if (tmr_done) state_d = ST_IDLE;
            ST_WARM_PULSE: if (tmr_done) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        pgood  = pwr_en;
        init_n = 1'b1;
        busy   = 1'b1;
        unique case (state_q)
            ST_IDLE:       busy   = 1'b0;
            ST_COLD_DROP:  pgood  = 1'b0;
            ST_WARM_PULSE: init_n = 1'b0;
            default:       busy   = 1'b0;
        endcase
    end

    // R3
    cold_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cold && !busy && pgood) |=> (!pgood && busy && init_n));

    // R4
    cold_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cold && !busy && !pgood) |=> (!busy && init_n));

    // R5
    warm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_cold && !busy) |=> (!init_n && busy && pgood == pwr_en));

    // R6
    idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (init_n && pgood == pwr_en));

    // R6
    one_pulse_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!init_n, (!pgood && pwr_en)}));

endmodule

// File: tb/plat_rst_pulser_tb.sv
module plat_rst_pulser_tb;

    localparam int CLK_MHZ = 125;
    localparam int COLD_W  = (CLK_MHZ * 100000 + 999) / 1000;  // 12500
    localparam int WARM_W  = (CLK_MHZ * 10000 + 999) / 1000;   // 1250
    localparam int WIN     = COLD_W + 500;
    localparam int NROW    = 6;

    // pwr, cold, inject_at(-1 none), inject_cold, exp_busy, exp_pg_low, exp_init_low
    localparam int VEC [0:NROW-1][0:6] = '{
        '{1, 1,   -1, 0, COLD_W, COLD_W, 0},      // R3 R6 cold, pgood high
        '{1, 0,   -1, 0, WARM_W, 0,      WARM_W}, // R5 R6 warm, pgood high
        '{0, 1,   -1, 0, 0,      WIN,    0},      // R4 cold skipped
        '{0, 0,   -1, 0, WARM_W, WIN,    WARM_W}, // R9 warm with pgood low
        '{1, 1,  200, 0, COLD_W, COLD_W, 0},      // R7 warm dropped in cold
        '{1, 0,  100, 1, WARM_W, 0,      WARM_W}  // R7 cold dropped in warm
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_en = 1'b0;
    logic req_valid = 1'b0;
    logic req_cold = 1'b0;
    logic pgood, init_n, busy;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    plat_rst_pulser #(.CLK_MHZ(CLK_MHZ)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_en    (pwr_en),
        .req_valid (req_valid),
        .req_cold  (req_cold),
        .pgood     (pgood),
        .init_n    (init_n),
        .busy      (busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue a one-cycle request; returns at the negedge after the capturing posedge.
    task automatic pulse_req(input bit cold);
        req_valid = 1'b1;
        req_cold  = cold;
        @(negedge clk);
        req_valid = 1'b0;
        req_cold  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        pwr_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 init_n", init_n, 1);
        check("R1 pgood", pgood, 1);
        pwr_en = 1'b0;
        #1;
        check("R1 pgood follows", pgood, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 idle follow
        pwr_en = 1'b1;
        #1;
        check("R2 pgood rise", pgood, 1);
        pwr_en = 1'b0;
        #1;
        check("R2 pgood fall", pgood, 0);
        @(negedge clk);

        for (int r = 0; r < NROW; r++) begin
            int nb, np, ni;
            nb = 0; np = 0; ni = 0;
            pwr_en = VEC[r][0][0];
            @(negedge clk);
            req_valid = 1'b1;
            req_cold  = VEC[r][1][0];
            @(negedge clk);
            req_valid = 1'b0;
            req_cold  = 1'b0;
            // R6 busy starts the cycle after the request
            check($sformatf("R6 row%0d busy start", r), busy, (VEC[r][4] > 0) ? 1 : 0);
            for (int i = 0; i < WIN; i++) begin
                if (i == VEC[r][2]) begin
                    req_valid = 1'b1;
                    req_cold  = VEC[r][3][0];
                end else begin
                    req_valid = 1'b0;
                    req_cold  = 1'b0;
                end
                if (busy)   nb++;
                if (!pgood) np++;
                if (!init_n) ni++;
                @(negedge clk);
            end
            req_valid = 1'b0;
            check($sformatf("R6 row%0d busy width", r), nb, VEC[r][4]);
            check($sformatf("R3 row%0d pgood low width", r), np, VEC[r][5]);
            check($sformatf("R5 row%0d init low width", r), ni, VEC[r][6]);
            check($sformatf("R2 row%0d pgood restored", r), pgood, VEC[r][0]);
        end

        // R4: after skipped cold, raising pwr_en shows no pending dropout
        pwr_en = 1'b0;
        @(negedge clk);
        pulse_req(1'b1);
        pwr_en = 1'b1;
        #1;
        check("R4 pgood after skip", pgood, 1);
        check("R4 busy after skip", busy, 0);
        @(negedge clk);

        // R8 back-to-back: warm, then cold in first idle cycle
        pulse_req(1'b0);
        while (busy) @(negedge clk);
        pulse_req(1'b1);
        check("R8 cold accepted at once", busy, 1);
        check("R8 pgood dropped", pgood, 0);
        while (busy) @(negedge clk);
        check("R3 pgood back", pgood, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule